// File: doc/BRIEF.md
# Socket Transmit Pointer and Segmentation Engine

This block does the transmit bookkeeping for one socket of a packet offload engine. The host places payload bytes into a power-of-two buffer RAM at the current write pointer. It then moves the write pointer forward by the number of bytes it queued and issues a send request. Both pointers are free-running 16-bit counters. The buffer address is the low part of a pointer, so data wraps around the end of the buffer without any help from the host.

On an accepted send request the block takes the pending length as write pointer minus read pointer, modulo 2^16. It then streams that many bytes out of the buffer, one per cycle, in segments no longer than a parameterised maximum (1460 by default). Each segment is marked with start and end strobes. The read pointer steps once per byte. When it catches up with the write pointer, a completion flag is raised.

A pending length larger than the buffer can only come from a bad write-pointer value, such as writing the byte count instead of the advanced pointer. Such a request is refused with an error flag, so it cannot turn into a flood of stale data. The free-space output always reports the room left for the host.

Top module: `txq_tx_engine`

## Requirements
- R1: After reset, wr_ptr and rd_ptr are both 0, free_bytes equals the buffer size (2048 by default), and busy, send_ok, send_err and tx_valid are all 0.
- R2: While the block is idle, a cycle with wptr_we high loads wptr_wdata into wr_ptr. free_bytes always equals the buffer size minus ((wr_ptr - rd_ptr) mod 2^16), clamped at 0 when the difference exceeds the buffer size.
- R3: A byte written with buf_we at pointer p is stored at RAM address p mod buffer size. A send emits the bytes at pointers rd_ptr, rd_ptr+1, … in order, wrapping across the end of the buffer.
- R4: An accepted send emits exactly (wr_ptr - rd_ptr) mod 2^16 bytes, one per cycle. rd_ptr advances by one per byte and ends equal to wr_ptr.
- R5: Emitted data is split into segments of at most MSS bytes (default 1460). tx_sof marks the first byte and tx_eof the last byte of every segment, so n bytes make ceil(n/MSS) segments, and only the last one may be short.
- R6: send_ok rises in the cycle rd_ptr reaches wr_ptr and stays high until the next accepted send. A send with zero pending sets send_ok at once and emits nothing.
- R7: A send whose pending length exceeds the buffer size is refused. send_err is set, no byte is emitted, and rd_ptr is unchanged. A pending length equal to the buffer size is accepted. An accepted send clears both send_ok and send_err.
- R8: A send_req that arrives while busy is high is ignored. The running transfer neither restarts nor changes length.
- R9: A wptr_we write that arrives while busy is high is ignored, and wr_ptr keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Host byte write into the buffer RAM |
| buf_ptr | input | 16 | Pointer value at which the host byte is placed |
| buf_wdata | input | 8 | Host byte |
| wptr_we | input | 1 | Load a new write pointer (honoured only when idle) |
| wptr_wdata | input | 16 | New write pointer value |
| send_req | input | 1 | Send request pulse |
| wr_ptr | output | 16 | Current write pointer |
| rd_ptr | output | 16 | Current read pointer |
| free_bytes | output | 16 | Free space left in the buffer |
| busy | output | 1 | A transfer is in progress |
| send_ok | output | 1 | Completion flag |
| send_err | output | 1 | Oversize-request flag |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a segment |
| tx_eof | output | 1 | Last byte of a segment |

## Verification
The hardest situations to reach are a transfer that crosses the physical end of the buffer and one whose pending length is the modulo-2^16 difference of pointers that straddle a bogus value. The bench first moves the pointers forward through real sends until the read pointer sits just below the buffer end, so the next 1460-byte send wraps. It then writes a small write-pointer value under a large read pointer, so the wrapped difference far exceeds the buffer. Requests collide with a running transfer by pulsing send_req and wptr_we twenty cycles into a long send. The exact-buffer-size and one-over cases sit on the rejection boundary.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic {TQ_IDLE = 1'b0, TQ_RUN = 1'b1} tq_state_e;

  // Bytes queued between two free-running pointers (mod 2^16).
  function automatic logic [15:0] ptr_gap(input logic [15:0] wr, input logic [15:0] rd);
    return wr - rd;
  endfunction

  // Room left in a buffer of buf_bytes, clamped at zero.
  function automatic logic [15:0] room_left(input logic [15:0] gap, input int unsigned buf_bytes);
    if (32'(gap) >= buf_bytes) return 16'd0;
    return 16'(buf_bytes - 32'(gap));
  endfunction

  // True when a pending length cannot be held by the buffer.
  function automatic logic gap_too_big(input logic [15:0] gap, input int unsigned buf_bytes);
    return 32'(gap) > buf_bytes;
  endfunction

endpackage

// File: rtl/txq_buf_ram.sv
module txq_buf_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txq_ptr_regs.sv
module txq_ptr_regs
  import txq_pkg::*;
#(
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wp_we,
  input  logic [15:0] wp_val,
  input  logic        busy,
  input  logic        rd_adv,
  output logic [15:0] wr_ptr,
  output logic [15:0] rd_ptr,
  output logic [15:0] pend,
  output logic [15:0] free_bytes
);
  logic wp_take;

  assign wp_take    = wp_we && !busy;
  assign pend       = ptr_gap(wr_ptr, rd_ptr);
  assign free_bytes = room_left(pend, BUF_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= 16'd0;
      rd_ptr <= 16'd0;
    end else begin
      if (wp_take) wr_ptr <= wp_val;
      if (rd_adv)  rd_ptr <= rd_ptr + 16'd1;
    end
  end

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wp_we) |=> wr_ptr == $past(wr_ptr));

  assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |=> rd_ptr == $past(rd_ptr) + 16'd1);

  assert_rd_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_adv |=> rd_ptr == $past(rd_ptr));

  assert_free_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_bytes) <= BUF_BYTES);
endmodule

// File: rtl/txq_seg_ctrl.sv
module txq_seg_ctrl
  import txq_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MSS       = 1460
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         send_req,
  input  logic [15:0]                  pend,
  input  logic [15:0]                  rd_ptr,
  output logic                         busy,
  output logic                         rd_adv,
  output logic                         last_rd,
  output logic [$clog2(BUF_BYTES)-1:0] ram_raddr,
  output logic                         out_valid,
  output logic                         out_sof,
  output logic                         out_eof,
  output logic                         send_ok,
  output logic                         send_err
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int SW = $clog2(MSS + 1);

  tq_state_e      state;
  logic [15:0]    remain;
  logic [SW-1:0]  seg_cnt;
  logic           accept;
  logic           refuse;
  logic           seg_end;
  logic           run;

  assign run       = (state == TQ_RUN);
  assign busy      = run;
  assign accept    = send_req && !run;
  assign refuse    = gap_too_big(pend, BUF_BYTES);
  assign last_rd   = run && (remain == 16'd1);
  assign seg_end   = (seg_cnt == SW'(MSS - 1)) || (remain == 16'd1);
  assign rd_adv    = run;
  assign ram_raddr = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TQ_IDLE;
      remain    <= 16'd0;
      seg_cnt   <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      send_ok   <= 1'b0;
      send_err  <= 1'b0;
    end else begin
      out_valid <= run;
      out_sof   <= run && (seg_cnt == '0);
      out_eof   <= run && seg_end;
      if (accept) begin
        send_ok  <= (pend == 16'd0);
        send_err <= refuse;
        seg_cnt  <= '0;
        if (!refuse && pend != 16'd0) begin
          state  <= TQ_RUN;
          remain <= pend;
        end
      end else if (run) begin
        remain  <= remain - 16'd1;
        seg_cnt <= seg_end ? '0 : seg_cnt + SW'(1);
        if (remain == 16'd1) begin
          state   <= TQ_IDLE;
          send_ok <= 1'b1;
        end
      end
    end
  end

  assert_eof_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  assert_sof_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    send_err |-> !busy);

  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> 32'(remain) <= BUF_BYTES);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && send_req && remain > 16'd1) |=> remain == $past(remain) - 16'd1);
endmodule

// File: rtl/txq_tx_engine.sv
module txq_tx_engine
  import txq_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MSS       = 1460
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        buf_we,
  input  logic [15:0] buf_ptr,
  input  logic [7:0]  buf_wdata,
  input  logic        wptr_we,
  input  logic [15:0] wptr_wdata,
  input  logic        send_req,
  output logic [15:0] wr_ptr,
  output logic [15:0] rd_ptr,
  output logic [15:0] free_bytes,
  output logic        busy,
  output logic        send_ok,
  output logic        send_err,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sof,
  output logic        tx_eof
);
  localparam int AW = $clog2(BUF_BYTES);

  logic [15:0]   pend;
  logic          rd_adv;
  logic          last_rd;
  logic [AW-1:0] ram_raddr;

  txq_ptr_regs #(.BUF_BYTES(BUF_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wp_we(wptr_we), .wp_val(wptr_wdata),
    .busy(busy), .rd_adv(rd_adv), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .pend(pend), .free_bytes(free_bytes)
  );

  txq_seg_ctrl #(.BUF_BYTES(BUF_BYTES), .MSS(MSS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .pend(pend),
    .rd_ptr(rd_ptr), .busy(busy), .rd_adv(rd_adv), .last_rd(last_rd),
    .ram_raddr(ram_raddr), .out_valid(tx_valid), .out_sof(tx_sof),
    .out_eof(tx_eof), .send_ok(send_ok), .send_err(send_err)
  );

  txq_buf_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(buf_we), .waddr(buf_ptr[AW-1:0]), .wdata(buf_wdata),
    .re(rd_adv), .raddr(ram_raddr), .rdata(tx_data)
  );

  assert_done_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_rd |=> (rd_ptr == wr_ptr) && send_ok);

  assert_ok_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_ok) |-> rd_ptr == wr_ptr);
endmodule

// File: tb/txq_tx_engine_bench.sv
module txq_tx_engine_bench;
  localparam int BUF = 2048;
  localparam int MSS = 1460;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_we = 1'b0;
  logic [15:0] buf_ptr = '0;
  logic [7:0] buf_wdata = '0;
  logic wptr_we = 1'b0;
  logic [15:0] wptr_wdata = '0;
  logic send_req = 1'b0;
  logic [15:0] wr_ptr, rd_ptr, free_bytes;
  logic busy, send_ok, send_err, tx_valid, tx_sof, tx_eof;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  txq_tx_engine #(.BUF_BYTES(BUF), .MSS(MSS)) u_txq_tx_engine (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_ptr(buf_ptr),
    .buf_wdata(buf_wdata), .wptr_we(wptr_we), .wptr_wdata(wptr_wdata),
    .send_req(send_req), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .free_bytes(free_bytes), .busy(busy), .send_ok(send_ok),
    .send_err(send_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] shadow [BUF];
  logic [7:0] cap [4096];
  int ncap = 0;
  int seg_len [8];
  int nseg = 0;
  int cur_len = 0;
  int frame_bad = 0;
  bit in_seg = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_free(input logic [15:0] w, input logic [15:0] r);
    int g;
    g = int'(16'(w - r));
    return (g >= BUF) ? 0 : BUF - g;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (tx_valid) begin
      if (ncap < 4096) cap[ncap] = tx_data;
      ncap++;
      if (tx_sof) begin
        if (in_seg) frame_bad++;
        in_seg = 1;
        cur_len = 0;
      end else if (!in_seg) frame_bad++;
      cur_len++;
      if (tx_eof) begin
        if (nseg < 8) seg_len[nseg] = cur_len;
        nseg++;
        in_seg = 0;
      end
    end else if (tx_sof || tx_eof) frame_bad++;
  end

  task automatic clear_cap();
    ncap = 0; nseg = 0; cur_len = 0; frame_bad = 0; in_seg = 0;
  endtask

  task automatic fill(input logic [15:0] start, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [15:0] p;
      p = start + 16'(i);
      @(negedge clk);
      buf_we = 1'b1; buf_ptr = p; buf_wdata = 8'(int'(p) * 13 + seed);
      shadow[int'(p) % BUF] = buf_wdata;
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic set_wp(input logic [15:0] v);
    @(negedge clk);
    wptr_we = 1'b1; wptr_wdata = v;
    @(negedge clk);
    wptr_we = 1'b0;
  endtask

  task automatic pulse_send();
    @(negedge clk);
    send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_stream(input string req, input logic [15:0] start, input int n);
    int bad = 0;
    check(ncap == n, {req, " byte count"}, ncap, n);
    for (int i = 0; i < n && i < 4096; i++)
      if (cap[i] !== shadow[(int'(start) + i) % BUF]) bad++;
    check(bad == 0, {req, " data order"}, bad, 0);
    check(frame_bad == 0, "R5 sof/eof framing", frame_bad, 0);
    check(nseg == (n + MSS - 1) / MSS, "R5 segment count", nseg, (n + MSS - 1) / MSS);
    for (int s = 0; s < nseg && s < 8; s++) begin
      int e;
      e = (n - s * MSS > MSS) ? MSS : n - s * MSS;
      check(seg_len[s] == e, "R5 segment length", seg_len[s], e);
    end
  endtask

  task automatic run_send(input string req, input int n, input int seed);
    logic [15:0] start;
    start = rd_ptr;
    fill(wr_ptr, n, seed);
    set_wp(wr_ptr + 16'(n));
    check(int'(free_bytes) == exp_free(wr_ptr, rd_ptr), "R2 free before send",
          int'(free_bytes), exp_free(wr_ptr, rd_ptr));
    clear_cap();
    pulse_send();
    wait_idle();
    check_stream(req, start, n);
    check(rd_ptr == wr_ptr, "R4 rd reaches wr", int'(rd_ptr), int'(wr_ptr));
    check(send_ok && !send_err, "R6 send_ok set", int'({send_ok, send_err}), 2);
    check(int'(free_bytes) == BUF, "R2 free after send", int'(free_bytes), BUF);
  endtask

  task automatic t_reset();
    check(wr_ptr == 0 && rd_ptr == 0, "R1 pointers zero", int'(wr_ptr) + int'(rd_ptr), 0);
    check(int'(free_bytes) == BUF, "R1 free size", int'(free_bytes), BUF);
    check({busy, send_ok, send_err, tx_valid} == 4'b0, "R1 flags low",
          int'({busy, send_ok, send_err, tx_valid}), 0);
  endtask

  task automatic t_zero();
    clear_cap();
    pulse_send();
    check(send_ok && !busy, "R6 zero pending send_ok", int'(send_ok), 1);
    repeat (3) @(negedge clk);
    check(ncap == 0, "R6 zero pending emits nothing", ncap, 0);
  endtask

  task automatic t_bogus(input logic [15:0] v, input string req);
    logic [15:0] r0, w0;
    r0 = rd_ptr;
    w0 = wr_ptr;
    set_wp(v);
    check(int'(free_bytes) == exp_free(v, r0), "R2 free clamp", int'(free_bytes), exp_free(v, r0));
    clear_cap();
    pulse_send();
    repeat (4) @(negedge clk);
    check(send_err && !send_ok, {req, " error flag"}, int'({send_err, send_ok}), 2);
    check(ncap == 0, {req, " nothing emitted"}, ncap, 0);
    check(rd_ptr == r0, {req, " rd unchanged"}, int'(rd_ptr), int'(r0));
    set_wp(w0);
  endtask

  task automatic t_busy();
    logic [15:0] start, tgt;
    start = rd_ptr;
    fill(wr_ptr, 1500, 5);
    tgt = wr_ptr + 16'd1500;
    set_wp(tgt);
    clear_cap();
    pulse_send();
    repeat (20) @(negedge clk);
    send_req = 1'b1; wptr_we = 1'b1; wptr_wdata = 16'h0003;
    @(negedge clk);
    send_req = 1'b0; wptr_we = 1'b0;
    check(wr_ptr == tgt, "R9 wr ignored while busy", int'(wr_ptr), int'(tgt));
    wait_idle();
    check(ncap == 1500, "R8 length unchanged", ncap, 1500);
    check_stream("R8", start, 1500);
    check(rd_ptr == tgt, "R4 rd reaches wr after collision", int'(rd_ptr), int'(tgt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    set_wp(16'd7);
    check(wr_ptr == 7 && int'(free_bytes) == BUF - 7, "R2 wr load and free",
          int'(free_bytes), BUF - 7);
    set_wp(16'd0);
    run_send("R4 short", 7, 1);
    run_send("R4 multi segment", 2000, 2);
    run_send("R3 wrap full mss", 1460, 3);
    t_zero();
    t_bogus(16'h0008, "R7 bogus pointer");
    t_busy();
    run_send("R7 exact buffer size", BUF, 4);
    t_bogus(rd_ptr + 16'(BUF + 1), "R7 one over buffer");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule